// File: doc/BRIEF.md
# Add-Side Telecom Bus Parity Checker

This block sits on the receive side of a byte-wide telecom add bus and checks every byte against the parity lead that travels with it. Each clock carries an 8-bit data lane, a frame-marker strobe (J0/J1 position), a payload-envelope strobe and one parity bit. The parity sense (even or odd) and whether the two timing strobes count towards the parity sum are set by static configuration inputs.

Upstream logic does not always present data and timing in the same cycle. The checker can therefore hold back the data and parity lanes by 0 to 15 cycles relative to the strobes, so the parity of each byte is checked together with the strobes that really belong to it. A separate control adds one register stage on every bus input when the upstream timing is too tight. The aligned bus is driven out with a per-byte error flag and a sticky error bit that is cleared by a write-one pulse.

When the skew setting changes, the delayed lane briefly pairs bytes with the wrong strobes. The error flag is therefore suppressed for a fixed window after any change of the skew setting.

Top module: `apc_par_chk`

## Requirements
- R1: With cfg_even_i = 1, a byte is in error when the count of ones over the covered bits plus the parity bit is odd.
- R2: With cfg_even_i = 0, a byte is in error when that count is even.
- R3: With cfg_cover_tim_i = 0 only data bits 7..0 and the parity bit are counted; with 1 the frame strobe and the envelope strobe are counted as well.
- R4: The data and parity lanes are delayed by cfg_skew_i cycles relative to the strobes, so a byte is checked against the strobes presented cfg_skew_i cycles after it. Its error shows on par_err_o, and its data on data_o, cfg_skew_i + 1 cycles after it was presented; frm_o and env_o follow the strobes by one cycle. A setting of 0 adds no delay.
- R5: With cfg_extra_i = 1 every bus input passes through one more register, so all outputs above appear one cycle later.
- R6: err_sticky_o goes high one cycle after par_err_o is high and stays high until a cycle where sticky_clr_i = 1 and par_err_o = 0.
- R7: In the cycle cfg_skew_i changes and for the DEPTH - 1 cycles after it, no byte can raise par_err_o.
- R8: While rst_ni is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Add bus data byte |
| frm_i | input | 1 | Frame-marker (J0/J1) strobe |
| env_i | input | 1 | Payload-envelope strobe |
| par_i | input | 1 | Parity lead |
| cfg_even_i | input | 1 | 1 selects even parity, 0 odd |
| cfg_cover_tim_i | input | 1 | 1 adds both strobes to the parity sum |
| cfg_skew_i | input | 4 | Data/parity delay behind the strobes, in cycles |
| cfg_extra_i | input | 1 | 1 adds one register stage on all inputs |
| sticky_clr_i | input | 1 | Write-one clear of the sticky bit |
| data_o | output | 8 | Aligned data byte |
| frm_o | output | 1 | Aligned frame strobe |
| env_o | output | 1 | Aligned envelope strobe |
| par_err_o | output | 1 | Per-byte parity error |
| err_sticky_o | output | 1 | Sticky parity error |

## Verification
The assertions take for granted that every input is a known value from the first clock after reset and that cfg_even_i, cfg_cover_tim_i and cfg_extra_i change only while the bus carries well-formed idle bytes, since only the skew setting has a protective mask. The bench keeps to this by changing those controls between scenarios and then running twenty idle bytes with correct parity before it inspects any result. Skew changes are followed by the same settling period, except in the scenario that deliberately places a bad byte inside the mask window.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int unsigned BUS_W = 8;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             frm;
    logic             env;
    logic             par;
  } bus_t;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             par;
  } lane_t;
endpackage

// File: rtl/apc_in_stage.sv
module apc_in_stage
  import apc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic extra_i,
  input  bus_t bus_i,
  output bus_t bus_o
);
  bus_t bus_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      bus_q  <= bus_i;
      seen_q <= 1'b1;
    end
  end

  assign bus_o = extra_i ? bus_q : bus_i;

  // R5: extra stage presents last cycle's bus
  a_r5_extra_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && extra_i) |-> (bus_o == $past(bus_i)));
endmodule

// File: rtl/apc_skew_line.sv
module apc_skew_line
  import apc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  lane_t            lane_i,
  output lane_t            lane_o
);
  lane_t stg_q [1:DEPTH-1];
  logic  seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q[1] <= '0;
      seen_q   <= 1'b0;
    end else begin
      stg_q[1] <= lane_i;
      seen_q   <= 1'b1;
    end
  end

  for (genvar g = 2; g < DEPTH; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  always_comb begin
    if (sel_i == '0) lane_o = lane_i;
    else             lane_o = stg_q[sel_i];
  end

  // R4: first stage holds the previous lane value
  a_r4_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (stg_q[1] == $past(lane_i)));
endmodule

// File: rtl/apc_mask_ctl.sv
module apc_mask_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mask_o
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] cnt_q;
  logic             chg;

  assign chg    = (sel_i != sel_q);
  assign mask_o = chg || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (chg)               cnt_q <= SEL_W'(DEPTH - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: a change opens a window that outlives the change cycle
  a_r7_window_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> mask_o);
endmodule

// File: rtl/apc_par_chk.sv
module apc_par_chk
  import apc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] data_i,
  input  logic             frm_i,
  input  logic             env_i,
  input  logic             par_i,
  input  logic             cfg_even_i,
  input  logic             cfg_cover_tim_i,
  input  logic [SEL_W-1:0] cfg_skew_i,
  input  logic             cfg_extra_i,
  input  logic             sticky_clr_i,
  output logic [BUS_W-1:0] data_o,
  output logic             frm_o,
  output logic             env_o,
  output logic             par_err_o,
  output logic             err_sticky_o
);
  bus_t  bus_raw, bus_s;
  lane_t lane_in, lane_al;
  logic  mask, odd_sum, bad;
  logic  err_q, sticky_q;

  assign bus_raw = '{data: data_i, frm: frm_i, env: env_i, par: par_i};

  apc_in_stage u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .extra_i(cfg_extra_i),
    .bus_i  (bus_raw),
    .bus_o  (bus_s)
  );

  assign lane_in = '{data: bus_s.data, par: bus_s.par};

  apc_skew_line #(.DEPTH(DEPTH)) u_skew (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_skew_i),
    .lane_i (lane_in),
    .lane_o (lane_al)
  );

  apc_mask_ctl #(.DEPTH(DEPTH)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_skew_i),
    .mask_o (mask)
  );

  // strobes are undelayed; data/parity come from the skew tap
  assign odd_sum = (^lane_al.data) ^ lane_al.par
                 ^ (cfg_cover_tim_i & (bus_s.frm ^ bus_s.env));
  assign bad     = cfg_even_i ? odd_sum : ~odd_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
      data_o   <= '0;
      frm_o    <= 1'b0;
      env_o    <= 1'b0;
    end else begin
      err_q    <= bad & ~mask;
      sticky_q <= err_q | (sticky_q & ~sticky_clr_i);
      data_o   <= lane_al.data;
      frm_o    <= bus_s.frm;
      env_o    <= bus_s.env;
    end
  end

  assign par_err_o    = err_q;
  assign err_sticky_o = sticky_q;

  // R7: no flag from a masked evaluation
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(!mask));
  // R6: error sets the sticky bit
  a_r6_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> sticky_q);
  // R6: sticky holds without a clear
  a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q && !sticky_clr_i) |=> sticky_q);
endmodule

// File: tb/sim_apc_par_chk.sv
`timescale 1ns/1ps
module sim_apc_par_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       frm = 1'b0, env = 1'b0, par = 1'b0;
  logic       c_even = 1'b1, c_cov = 1'b0, c_extra = 1'b0, clr = 1'b0;
  logic [3:0] c_skew = '0;
  logic [7:0] data_o;
  logic       frm_o, env_o, err_o, sticky_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apc_par_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .frm_i(frm), .env_i(env),
    .par_i(par), .cfg_even_i(c_even), .cfg_cover_tim_i(c_cov),
    .cfg_skew_i(c_skew), .cfg_extra_i(c_extra), .sticky_clr_i(clr),
    .data_o(data_o), .frm_o(frm_o), .env_o(env_o), .par_err_o(err_o),
    .err_sticky_o(sticky_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // parity bit that makes a correct byte under the current settings
  function automatic logic good_par(logic [7:0] d, logic f, logic e);
    logic s;
    s = (^d) ^ (c_cov & (f ^ e));
    return c_even ? s : ~s;
  endfunction

  // present one byte for one cycle; bad=1 inverts the parity
  task automatic drv(logic [7:0] d, logic f, logic e, logic bad);
    data = d; frm = f; env = e;
    par  = good_par(d, f, e) ^ bad;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R8 err", err_o, 0);
    chk("R8 sticky", sticky_o, 0);
    chk("R8 data", data_o, 0);
  endtask

  task automatic t_even;
    c_even = 1'b1; c_cov = 1'b0; idle(20);
    drv(8'hA5, 0, 0, 0); chk("R1 good a5", err_o, 0);
    drv(8'h01, 0, 0, 0); chk("R1 good 01", err_o, 0);
    drv(8'h37, 0, 0, 1); chk("R1 bad 37", err_o, 1);
    chk("R1 data 37", data_o, 8'h37);
    drv(8'h00, 0, 0, 0); chk("R1 one-shot", err_o, 0);
  endtask

  task automatic t_odd;
    c_even = 1'b0; idle(20);
    drv(8'h00, 0, 0, 0); chk("R2 good 00", err_o, 0);
    data = 8'h00; par = 1'b0; @(negedge clk);
    chk("R2 bad 00 par0", err_o, 1);
    drv(8'hFF, 0, 0, 1); chk("R2 bad ff", err_o, 1);
    c_even = 1'b1; idle(20);
  endtask

  task automatic t_cover;
    c_cov = 1'b1; idle(20);
    data = 8'h00; frm = 1'b1; env = 1'b0; par = 1'b0; @(negedge clk);
    chk("R3 strobe counted", err_o, 1);
    data = 8'h00; frm = 1'b1; env = 1'b1; par = 1'b0; @(negedge clk);
    chk("R3 both strobes", err_o, 0);
    c_cov = 1'b0; idle(20);
    data = 8'h00; frm = 1'b1; env = 1'b0; par = 1'b0; @(negedge clk);
    chk("R3 strobe ignored", err_o, 0);
    chk("R4 frm_o one cycle", frm_o, 1);
    idle(2);
  endtask

  task automatic t_skew(int s);
    c_skew = 4'(s); idle(20);
    drv(8'h5A, 0, 0, 1);
    for (int k = 0; k < s; k++) begin
      chk("R4 early", err_o, 0);
      idle(1);
    end
    chk("R4 err at skew+1", err_o, 1);
    chk("R4 data at skew+1", data_o, 8'h5A);
    idle(1);
    chk("R4 after", err_o, 0);
  endtask

  task automatic t_skew_cov;
    c_skew = 4'd3; c_cov = 1'b1; idle(20);
    data = 8'h01; frm = 1'b0; env = 1'b0; par = 1'b0; @(negedge clk);
    chk("R4 no pairing now", err_o, 0);
    idle(2);
    data = 8'h00; frm = 1'b1; env = 1'b0; par = 1'b1; @(negedge clk);
    chk("R4 aligned strobe", err_o, 0);
    chk("R4 aligned data", data_o, 8'h01);
    chk("R4 aligned frm", frm_o, 1);
    c_cov = 1'b0; c_skew = 4'd0; idle(20);
  endtask

  task automatic t_extra;
    c_extra = 1'b1; idle(20);
    drv(8'hC3, 0, 0, 1); chk("R5 not yet", err_o, 0);
    idle(1); chk("R5 one later", err_o, 1);
    chk("R5 data later", data_o, 8'hC3);
    c_extra = 1'b0; idle(20);
  endtask

  task automatic t_sticky;
    clr = 1'b1; idle(1); clr = 1'b0; idle(1);
    chk("R6 cleared", sticky_o, 0);
    drv(8'h11, 0, 0, 1); chk("R6 err", err_o, 1);
    chk("R6 not yet", sticky_o, 0);
    idle(1); chk("R6 set", sticky_o, 1);
    idle(5); chk("R6 hold", sticky_o, 1);
    clr = 1'b1; idle(1); clr = 1'b0;
    chk("R6 clear", sticky_o, 0);
    drv(8'h22, 0, 0, 1);
    clr = 1'b1; idle(1); clr = 1'b0;
    chk("R6 set beats clear", sticky_o, 1);
    clr = 1'b1; idle(1); clr = 1'b0;
  endtask

  task automatic t_mask;
    c_skew = 4'd2;
    drv(8'h44, 0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R7 masked", err_o, 0);
      idle(1);
    end
    idle(16);
    drv(8'h44, 0, 0, 1); idle(2);
    chk("R7 unmasked", err_o, 1);
    c_skew = 4'd0; idle(20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_even();
    t_odd();
    t_cover();
    t_skew(5);
    t_skew(15);
    t_skew(0);
    t_skew_cov();
    t_extra();
    t_sticky();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule